// File: doc/BRIEF.md
# Asynchronous PSRAM Write Sequencer

This block is a clocked controller that carries out a single write on a 16-bit asynchronous pseudo-static RAM. A requester presents a word address, a data word and one enable bit per byte lane. When the sequencer is idle it takes the request and runs the write cycle on the memory pins. It first asserts both chip selects and the selected byte strobes together with the address. It then pulls the write strobe low and drives the data. The write ends when the write strobe rises while every other strobe is still active. Everything is released one cycle later, and a one-cycle done pulse follows.

Every interval is a whole number of clock cycles. The counts are worked out at elaboration time from the clock period parameter and the selected speed grade: grade 0 is the 55 ns part and grade 1 is the 70 ns part. Each nanosecond minimum is rounded up to the next full cycle.

Output enable stays high for the whole write. The bus release time therefore never lengthens the write pulse, and the block's own data drivers turn on only while the write strobe is low. A request with no byte lane enabled is accepted and completes without touching any strobe.

Top module: `psram_wr_seq`

## Requirements
- R1: The write strobe `mem_we_n` is low only while `mem_cs1_n` is 0, `mem_cs2` is 1 and at least one bit of `mem_bs_n` is 0.
- R2: A write ends with `mem_we_n` rising while both chip selects and the selected byte strobes are still active. All of them go inactive on the next cycle.
- R3: The write strobe stays low for exactly max(ceil(tPW/Tclk), ceil(tSD/Tclk)) cycles, where tPW is 45/60 ns and tSD is 25/30 ns for grade 0/1. The data is therefore driven for at least the setup time before the write ends.
- R4: The chip selects, address and byte strobes become valid one cycle before the write strobe falls. They stay valid for at least ceil(45 or 60 ns / Tclk) cycles before it rises.
- R5: `mem_addr` equals the accepted address from chip-select assertion until release. `mem_dout` equals the accepted data whenever `mem_dq_oe` is 1. Both stay unchanged while the write strobe is low, whatever the request inputs do after acceptance.
- R6: The number of cycles from chip-select assertion to the done pulse is at least ceil(tWC/Tclk), where tWC is 55/70 ns. It equals that value when the strobe phases are shorter than this minimum; otherwise it equals P+2, with P the pulse length from R3.
- R7: `mem_oe_n` stays 1 at all times. `mem_dq_oe` is 1 exactly during the cycles with `mem_we_n` low plus the single cycle in which `mem_we_n` rises.
- R8: Bit 1 of `mem_bs_n` (upper byte) is low during a write exactly when bit 1 of `req_be` was set. Bit 0 (lower byte) follows bit 0 of `req_be` in the same way.
- R9: A request with `req_be` = 0 is accepted and raises `done` in the cycle after acceptance, with no strobe asserted and the data drivers off.
- R10: `req_ready` is 1 only when the sequencer is idle. A request is taken when `req_valid` and `req_ready` are both 1. `done` is a single-cycle pulse, after which `req_ready` returns to 1.
- R11: While reset is applied, and directly after it, both chip selects, the write strobe and the byte strobes are inactive, `mem_dq_oe` and `done` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | 19 | Word address |
| req_data | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables, bit 1 upper, bit 0 lower |
| done | output | 1 | One-cycle pulse at the end of the write cycle |
| mem_addr | output | 19 | Memory address pins |
| mem_dout | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable (held high) |
| mem_bs_n | output | 2 | Active-low byte strobes, bit 1 upper, bit 0 lower |

## Verification
The hardest case to reach from the ports is the boundary where the write ends. In that single cycle the write strobe has already risen, the chip selects and byte strobes must still be active, and the data drivers must still be on. One cycle later everything has to let go. The stimulus checks each sampled cycle against the previous one, so the rising edge of the write strobe and the release that follows it are checked in every write. Random address, data and lane-enable patterns, including the empty-lane case, are mixed in. After each acceptance the request inputs are scrambled, to show that the pins hold the latched values through the whole cycle.

// File: rtl/psram_wr_pkg.sv
`timescale 1ns/1ps
package psram_wr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_PULSE = 3'd2,
      ST_HOLD  = 3'd3,
      ST_PAD   = 3'd4,
      ST_FIN   = 3'd5
   } wr_state_e;

   // ns to clock cycles, rounded up
   function automatic int ns_to_cyc(input int ns, input int period_ps);
      return (ns * 1000 + period_ps - 1) / period_ps;
   endfunction

   // minimum write cycle per grade
   function automatic int grade_cycle_ns(input int grade);
      return (grade == 0) ? 55 : 70;
   endfunction

   // minimum strobe low / select-to-end per grade
   function automatic int grade_strobe_ns(input int grade);
      return (grade == 0) ? 45 : 60;
   endfunction

   // minimum data-before-end per grade
   function automatic int grade_setup_ns(input int grade);
      return (grade == 0) ? 25 : 30;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_wr_fsm.sv
`timescale 1ns/1ps
module psram_wr_fsm
   import psram_wr_pkg::*;
#(
   parameter int PULSE_CYC = 3,
   parameter int PAD_CYC   = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      any_lane,
   output logic      accept,
   output logic      idle,
   output wr_state_e state_d,
   output wr_state_e state_q
);

   localparam int CNT_MAX  = imax(PULSE_CYC, PAD_CYC);
   localparam int CNT_W    = $clog2(CNT_MAX + 1) < 1 ? 1 : $clog2(CNT_MAX + 1);
   localparam int PLS_LOAD = PULSE_CYC - 1;
   localparam int PAD_LOAD = (PAD_CYC > 0) ? PAD_CYC - 1 : 0;

   logic [CNT_W-1:0] cnt_q, cnt_d;
   wr_state_e        after_hold;

   generate
      if (PAD_CYC > 0) begin : g_pad
         assign after_hold = ST_PAD;
      end else begin : g_nopad
         assign after_hold = ST_FIN;
      end
   endgenerate

   assign idle   = (state_q == ST_IDLE);
   assign accept = idle && req_valid;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) state_d = any_lane ? ST_SETUP : ST_FIN;
         end
         ST_SETUP: begin
            state_d = ST_PULSE;
            cnt_d   = CNT_W'(PLS_LOAD);
         end
         ST_PULSE: begin
            if (cnt_q == '0) state_d = ST_HOLD;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_HOLD: begin
            state_d = after_hold;
            cnt_d   = CNT_W'(PAD_LOAD);
         end
         ST_PAD: begin
            if (cnt_q == '0) state_d = ST_FIN;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/psram_wr_strobes.sv
`timescale 1ns/1ps
module psram_wr_strobes
   import psram_wr_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [LANES-1:0] req_be,
   input  wr_state_e        state_d,
   output logic             cs1_n,
   output logic             cs2,
   output logic             we_n,
   output logic             dq_oe,
   output logic             fin,
   output logic [LANES-1:0] bs_n
);

   logic [LANES-1:0] be_q, be_nx;
   logic             sel_nx;

   assign be_nx  = accept ? req_be : be_q;
   assign sel_nx = (state_d == ST_SETUP) || (state_d == ST_PULSE) || (state_d == ST_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         be_q  <= '0;
         cs1_n <= 1'b1;
         cs2   <= 1'b0;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
         fin   <= 1'b0;
      end else begin
         be_q  <= be_nx;
         cs1_n <= ~sel_nx;
         cs2   <= sel_nx;
         we_n  <= ~(state_d == ST_PULSE);
         dq_oe <= (state_d == ST_PULSE) || (state_d == ST_HOLD);
         fin   <= (state_d == ST_FIN);
      end
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bs_n[g] <= 1'b1;
            else        bs_n[g] <= ~(sel_nx && be_nx[g]);
         end
      end
   endgenerate

endmodule

// File: rtl/psram_wr_hold.sv
`timescale 1ns/1ps
module psram_wr_hold #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         addr_q <= req_addr;
         data_q <= req_data;
      end
   end

endmodule

// File: rtl/psram_wr_seq.sv
`timescale 1ns/1ps
module psram_wr_seq
   import psram_wr_pkg::*;
#(
   parameter int ADDR_W        = 19,
   parameter int DATA_W        = 16,
   parameter int GRADE         = 0,
   parameter int CLK_PERIOD_PS = 10000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_data,
   input  logic [DATA_W/8-1:0] req_be,
   output logic                done,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_dout,
   output logic                mem_dq_oe,
   output logic                mem_cs1_n,
   output logic                mem_cs2,
   output logic                mem_we_n,
   output logic                mem_oe_n,
   output logic [DATA_W/8-1:0] mem_bs_n
);

   localparam int LANES      = DATA_W / 8;
   localparam int WC_CYC     = ns_to_cyc(grade_cycle_ns(GRADE), CLK_PERIOD_PS);
   localparam int STROBE_CYC = ns_to_cyc(grade_strobe_ns(GRADE), CLK_PERIOD_PS);
   localparam int SETUP_CYC  = ns_to_cyc(grade_setup_ns(GRADE), CLK_PERIOD_PS);
   localparam int PULSE_CYC  = imax(imax(STROBE_CYC, SETUP_CYC), 1);
   localparam int BODY_CYC   = PULSE_CYC + 2;
   localparam int PAD_CYC    = (WC_CYC > BODY_CYC) ? WC_CYC - BODY_CYC : 0;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a positive multiple of 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (GRADE < 0 || GRADE > 1) begin : g_bad_grade
         $error("GRADE must be 0 or 1");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_clk
         $error("CLK_PERIOD_PS must be positive");
      end
   endgenerate

   wr_state_e state_d, state_q;
   logic      accept, idle;

   psram_wr_fsm #(
      .PULSE_CYC(PULSE_CYC),
      .PAD_CYC  (PAD_CYC)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .any_lane (|req_be),
      .accept   (accept),
      .idle     (idle),
      .state_d  (state_d),
      .state_q  (state_q)
   );

   psram_wr_strobes #(
      .LANES(LANES)
   ) u_strobes (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .req_be (req_be),
      .state_d(state_d),
      .cs1_n  (mem_cs1_n),
      .cs2    (mem_cs2),
      .we_n   (mem_we_n),
      .dq_oe  (mem_dq_oe),
      .fin    (done),
      .bs_n   (mem_bs_n)
   );

   psram_wr_hold #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .req_addr(req_addr),
      .req_data(req_data),
      .addr_q  (mem_addr),
      .data_q  (mem_dout)
   );

   assign req_ready = idle;
   assign mem_oe_n  = 1'b1;

endmodule

// File: rtl/psram_wr_seq_chk.sv
`timescale 1ns/1ps
module psram_wr_seq_chk #(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 16,
   parameter int PULSE_CYC = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_ready,
   input logic                done,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W-1:0]   mem_dout,
   input logic                mem_dq_oe,
   input logic                mem_cs1_n,
   input logic                mem_cs2,
   input logic                mem_we_n,
   input logic                mem_oe_n,
   input logic [DATA_W/8-1:0] mem_bs_n
);

   logic [15:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         low_run <= '0;
      else if (!mem_we_n) low_run <= low_run + 1'b1;
      else                low_run <= '0;
   end

   AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs1_n && mem_cs2 && !(&mem_bs_n))); // R1
   AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_cs1_n && mem_cs2 && !(&mem_bs_n))); // R2
   AST_RELEASE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |=> (mem_cs1_n && !mem_cs2 && (&mem_bs_n))); // R2
   AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (low_run == 16'(PULSE_CYC))); // R3
   AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout))); // R5
   AST_DRIVE_WITH_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R7
   AST_DRIVE_STARTS_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> !mem_we_n); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_READY_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs1_n && mem_we_n && !mem_dq_oe)); // R10

endmodule

bind psram_wr_seq psram_wr_seq_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .PULSE_CYC(PULSE_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .done     (done),
   .mem_addr (mem_addr),
   .mem_dout (mem_dout),
   .mem_dq_oe(mem_dq_oe),
   .mem_cs1_n(mem_cs1_n),
   .mem_cs2  (mem_cs2),
   .mem_we_n (mem_we_n),
   .mem_oe_n (mem_oe_n),
   .mem_bs_n (mem_bs_n)
);

// File: tb/psram_wr_seq_tb_top.sv
`timescale 1ns/1ps
module psram_wr_seq_tb_top;

   localparam int TB_GRADE = 0;
   localparam int TB_PS    = 20000;

   function automatic int up_cyc(input int ns);
      return (ns * 1000 + TB_PS - 1) / TB_PS;
   endfunction
   function automatic int wc_ns();  return TB_GRADE == 0 ? 55 : 70; endfunction
   function automatic int pw_ns();  return TB_GRADE == 0 ? 45 : 60; endfunction
   function automatic int sd_ns();  return TB_GRADE == 0 ? 25 : 30; endfunction
   function automatic int exp_pulse();
      return up_cyc(pw_ns()) > up_cyc(sd_ns()) ? up_cyc(pw_ns()) : up_cyc(sd_ns());
   endfunction
   function automatic int exp_total();
      return (exp_pulse() + 2 > up_cyc(wc_ns())) ? exp_pulse() + 2 : up_cyc(wc_ns());
   endfunction

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [18:0] req_addr = '0;
   logic [15:0] req_data = '0;
   logic [1:0]  req_be = '0;
   logic        done;
   logic [18:0] mem_addr;
   logic [15:0] mem_dout;
   logic        mem_dq_oe, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n;
   logic [1:0]  mem_bs_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   psram_wr_seq #(
      .ADDR_W(19), .DATA_W(16), .GRADE(TB_GRADE), .CLK_PERIOD_PS(TB_PS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .done(done),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe),
      .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_bs_n(mem_bs_n)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
      int  idx = 0;
      int  we_low = 0;
      int  cs_cnt = 0;
      int  rise_idx = -1;
      bit  prev_low = 1'b0;
      bit  fin = 1'b0;
      bit  cs_on;
      @(negedge clk);
      chk(req_ready === 1'b1, "R10 ready when idle", req_ready, 1);
      req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr = 19'($urandom); req_data = 16'($urandom); req_be = 2'($urandom);
      if (be == 2'b00) begin
         chk(done === 1'b1, "R9 done after empty request", done, 1);
         chk(mem_cs1_n === 1'b1 && mem_cs2 === 1'b0 && mem_we_n === 1'b1 &&
             mem_bs_n === 2'b11 && mem_dq_oe === 1'b0, "R9 no strobe",
             {mem_cs1_n, mem_cs2, mem_we_n, mem_bs_n, mem_dq_oe}, 6'b101110);
         @(negedge clk);
         chk(done === 1'b0 && req_ready === 1'b1, "R10 back to idle", {done, req_ready}, 2'b01);
         return;
      end
      while (!fin && idx < 64) begin
         cs_on = !mem_cs1_n && mem_cs2;
         if (idx == 0)
            chk(cs_on && mem_we_n, "R4 select before strobe", {cs_on, mem_we_n}, 2'b11);
         chk(mem_oe_n === 1'b1, "R7 output enable high", mem_oe_n, 1);
         if (!mem_we_n)
            chk(cs_on && mem_bs_n != 2'b11, "R1 strobe only when selected", {cs_on, mem_bs_n}, 3'b100);
         if (cs_on) begin
            cs_cnt++;
            chk(mem_addr == a, "R5 address", mem_addr, a);
            chk(mem_bs_n == ~be, "R8 byte lanes", mem_bs_n, ~be);
         end
         if (mem_dq_oe) chk(mem_dout == d, "R5 data", mem_dout, d);
         chk(mem_dq_oe === (!mem_we_n || (prev_low && mem_we_n)), "R7 driver window",
             mem_dq_oe, (!mem_we_n || (prev_low && mem_we_n)));
         if (prev_low && mem_we_n) begin
            rise_idx = idx;
            chk(we_low == exp_pulse(), "R3 pulse length", we_low, exp_pulse());
            chk(we_low >= up_cyc(sd_ns()), "R3 data setup", we_low, up_cyc(sd_ns()));
            chk(cs_on && mem_bs_n == ~be, "R2 end by strobe", {cs_on, mem_bs_n}, {1'b1, ~be});
            chk(cs_cnt - 1 >= up_cyc(pw_ns()), "R4 select to end", cs_cnt - 1, up_cyc(pw_ns()));
         end
         if (rise_idx >= 0 && idx == rise_idx + 1)
            chk(!cs_on && mem_bs_n == 2'b11, "R2 release after end", {cs_on, mem_bs_n}, 3'b011);
         if (!mem_we_n) we_low++;
         prev_low = !mem_we_n;
         if (done) begin
            fin = 1'b1;
            chk(idx == exp_total(), "R6 cycle length", idx, exp_total());
            chk(idx >= up_cyc(wc_ns()), "R6 minimum cycle", idx, up_cyc(wc_ns()));
            chk(rise_idx >= 0, "R2 write ended", rise_idx, 0);
         end else begin
            @(negedge clk);
            idx++;
         end
      end
      if (!fin) chk(1'b0, "R10 done never seen", 0, 1);
      @(negedge clk);
      chk(done === 1'b0 && req_ready === 1'b1, "R10 single done pulse", {done, req_ready}, 2'b01);
   endtask

   initial begin
      #3000000;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(mem_cs1_n === 1'b1 && mem_cs2 === 1'b0 && mem_we_n === 1'b1 && mem_bs_n === 2'b11,
          "R11 strobes in reset", {mem_cs1_n, mem_cs2, mem_we_n, mem_bs_n}, 5'b10111);
      chk(mem_dq_oe === 1'b0 && done === 1'b0 && req_ready === 1'b1, "R11 outputs in reset",
          {mem_dq_oe, done, req_ready}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_cs1_n === 1'b1 && req_ready === 1'b1 && done === 1'b0, "R11 after reset",
          {mem_cs1_n, req_ready, done}, 3'b110);
      do_write(19'h00000, 16'h0000, 2'b11);
      do_write(19'h7FFFF, 16'hFFFF, 2'b11);
      do_write(19'h2AAAA, 16'hA5A5, 2'b01);
      do_write(19'h55555, 16'h5A5A, 2'b10);
      do_write(19'h12345, 16'hBEEF, 2'b00);
      do_write(19'h00001, 16'h8001, 2'b11);
      for (int i = 0; i < 200; i++)
         do_write(19'($urandom), 16'($urandom), 2'($urandom));
      do_write(19'h0F0F0, 16'h1234, 2'b00);
      do_write(19'h70F0F, 16'hCAFE, 2'b10);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule